// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Transfer Length Counter

This block sits between host register accesses and the data path of a SCSI controller. Host writes to the data port push bytes into a small byte FIFO, and host reads pop them out. While a command phase is pending, host writes go to a separate command buffer instead, filled at an incrementing index. A consumer reads that buffer and releases it once the command has been taken.

A 16-bit transfer counter sits alongside the FIFO. It sets the length of each transfer-information step. A programmed value of zero stands for the full 65536-byte range. The block reports the effective length of the next step: outside a command phase this is the counter value capped at the bytes held in the FIFO, and in a command phase it is the counter value capped at the command limit.

When a DMA transfer ends, the block raises a terminal-count flag, clears the counter and empties the FIFO. A status response loads the FIFO with the two-byte reply, so that the host can read it back. Bus-phase sequencing is handled elsewhere.

Top module: `pio_xfer_fifo`

## Requirements
- R1: After reset, `fill_level`, `tc_flag`, `rd_data`, `cmd_len`, `pop_irq` and `xfer_len` are all 0.
- R2: A write with `cmd_pend` low and fewer than 15 bytes held stores `wr_data`. Bytes leave in arrival order. A read with data held updates `rd_data` at the same clock edge and lowers `fill_level` by one. `pop_irq` is high for exactly the one cycle after that edge.
- R3: A write that arrives while 15 bytes are held is dropped, and `fill_level` stays at 15.
- R4: While `cmd_pend` is high, writes go to the command buffer at index `cmd_len`, which then increments. The command buffer saturates at 32 bytes. `fill_level` is unchanged. `cmd_rd_data` shows the entry selected by `cmd_rd_addr`. A `cmd_take` pulse returns `cmd_len` to 0.
- R5: A read with data held while `phase` (status bits 2:1) equals 2'b00, which is data-out, still pops a byte but returns 0x00 on `rd_data`.
- R6: A read while the FIFO is empty leaves `rd_data` unchanged, keeps `fill_level` at 0 and does not pulse `pop_irq`.
- R7: `cnt_load` stores `cnt_value`. A stored value of 0 counts as 65536. With `cmd_pend` low, `xfer_len` is the smaller of that count and `fill_level`.
- R8: With `cmd_pend` high, `xfer_len` is the smaller of the count (0 read as 65536) and 32.
- R9: `xfer_done` sets `tc_flag`, clears the count to 0 and empties the FIFO. A later `cnt_load` clears `tc_flag`.
- R10: `status_load` places `status_byte` followed by 0x00 in the FIFO, discarding earlier contents, and `fill_level` becomes 2.
- R11: When `status_load`, `xfer_done` and a data write occur in the same cycle, the status reply defines the FIFO contents. `xfer_done` still sets `tc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe to the data port |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe from the data port |
| cmd_pend | input | 1 | Command phase pending; steers writes to the command buffer |
| phase | input | 2 | Bus phase bits (status bits 2:1); 2'b00 is data-out |
| cnt_load | input | 1 | Load the transfer counter |
| cnt_value | input | 16 | Counter value to load |
| xfer_done | input | 1 | DMA transfer finished |
| status_load | input | 1 | Load the two-byte status reply |
| status_byte | input | 8 | Status byte for the reply |
| cmd_take | input | 1 | Release the command buffer |
| cmd_rd_addr | input | 5 | Command buffer read index |
| rd_data | output | 8 | Byte returned by the last read |
| pop_irq | output | 1 | One-cycle interrupt after a read with data |
| fill_level | output | 5 | Bytes held in the FIFO |
| cmd_len | output | 6 | Bytes held in the command buffer |
| cmd_rd_data | output | 8 | Command buffer entry at `cmd_rd_addr` |
| xfer_len | output | 17 | Effective length of the next transfer step |
| tc_flag | output | 1 | Terminal count reached |

## Verification
The bench fills the FIFO past its limit. A design that accepts a 16th byte reports a fill of 16 and hands back an extra byte. It also reads an empty FIFO, where a faulty pointer update returns stale memory or pulses the interrupt. It programs a zero count in command phase, where a design that treats zero literally reports a length of 0 instead of 32. Finally, it fires status load, transfer done and a write together: a wrong priority shows up as a fill other than 2, or as the written byte appearing in the reply.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
   typedef enum logic [1:0] {
      FOP_RW     = 2'd0,
      FOP_FLUSH  = 2'd1,
      FOP_STATUS = 2'd2
   } fifo_op_e;

   function automatic logic [31:0] min_u32(input logic [31:0] a, input logic [31:0] b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/byte_fifo_core.sv
module byte_fifo_core
   import pio_fifo_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fifo_op_e         op,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             pop,
   input  logic             zero_out,
   input  logic [DW-1:0]    stat_data,
   output logic [DW-1:0]    rd_data,
   output logic [LVL_W-1:0] level,
   output logic             popped
);
   localparam logic [LVL_W-1:0] OVR_LVL = LVL_W'(DEPTH - 1);

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] rptr, wptr;
   logic             do_push, do_pop;
   logic [LVL_W-1:0] next_level;

   assign do_push    = push && (level != OVR_LVL);
   assign do_pop     = pop && (level != '0);
   assign next_level = level + LVL_W'(do_push) - LVL_W'(do_pop);

   always_ff @(posedge clk) begin
      if (op == FOP_STATUS) begin
         mem[0] <= stat_data;
         mem[1] <= '0;
      end else if (op == FOP_RW && do_push) begin
         mem[wptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr    <= '0;
         wptr    <= '0;
         level   <= '0;
         rd_data <= '0;
         popped  <= 1'b0;
      end else begin
         popped <= 1'b0;
         case (op)
            FOP_STATUS: begin
               rptr  <= '0;
               wptr  <= PTR_W'(2);
               level <= LVL_W'(2);
            end
            FOP_FLUSH: begin
               rptr  <= '0;
               wptr  <= '0;
               level <= '0;
            end
            default: begin
               if (do_push) wptr <= wptr + 1'b1;
               if (do_pop) begin
                  rd_data <= zero_out ? '0 : mem[rptr];
                  rptr    <= rptr + 1'b1;
                  popped  <= 1'b1;
               end
               level <= next_level;
               if (next_level == '0) begin
                  rptr <= '0;
                  wptr <= '0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cmd_buffer.sv
module cmd_buffer #(
   parameter int DW        = 8,
   parameter int CMD_DEPTH = 32,
   localparam int IDX_W = $clog2(CMD_DEPTH),
   localparam int LEN_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             clear,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [DW-1:0]    rd_data,
   output logic [LEN_W-1:0] len
);
   localparam logic [LEN_W-1:0] FULL = LEN_W'(CMD_DEPTH);

   logic [DW-1:0] ent [CMD_DEPTH];
   logic          accept;

   assign accept = push && !clear && (len != FULL);

   for (genvar i = 0; i < CMD_DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (accept && len == LEN_W'(i)) ent[i] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) len <= '0;
      else if (accept)     len <= len + 1'b1;
   end

   assign rd_data = ent[rd_addr];
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter
   import pio_fifo_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CMD_CAP     = 32,
   parameter int LVL_W       = 5,
   parameter bit ZERO_IS_MAX = 1'b1,
   localparam int LEN_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] value,
   input  logic             done,
   input  logic             cmd_mode,
   input  logic [LVL_W-1:0] level,
   output logic [LEN_W-1:0] len,
   output logic             tc
);
   logic [CNT_W-1:0] cnt;
   logic [LEN_W-1:0] eff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         tc  <= 1'b0;
      end else if (done) begin
         cnt <= '0;
         tc  <= 1'b1;
      end else if (load) begin
         cnt <= value;
         tc  <= 1'b0;
      end
   end

   if (ZERO_IS_MAX) begin : g_zero_max
      assign eff = (cnt == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, cnt};
   end else begin : g_zero_lit
      assign eff = {1'b0, cnt};
   end

   always_comb begin
      if (cmd_mode) len = LEN_W'(min_u32(32'(eff), 32'(CMD_CAP)));
      else          len = LEN_W'(min_u32(32'(eff), 32'(level)));
   end
endmodule

// File: rtl/pio_xfer_fifo.sv
module pio_xfer_fifo
   import pio_fifo_pkg::*;
#(
   parameter int DW        = 8,
   parameter int DEPTH     = 16,
   parameter int CMD_DEPTH = 32,
   parameter int CNT_W     = 16,
   localparam int LVL_W   = $clog2(DEPTH) + 1,
   localparam int CIDX_W  = $clog2(CMD_DEPTH),
   localparam int CLEN_W  = CIDX_W + 1,
   localparam int XLEN_W  = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_data,
   input  logic              rd_en,
   input  logic              cmd_pend,
   input  logic [1:0]        phase,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_value,
   input  logic              xfer_done,
   input  logic              status_load,
   input  logic [DW-1:0]     status_byte,
   input  logic              cmd_take,
   input  logic [CIDX_W-1:0] cmd_rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              pop_irq,
   output logic [LVL_W-1:0]  fill_level,
   output logic [CLEN_W-1:0] cmd_len,
   output logic [DW-1:0]     cmd_rd_data,
   output logic [XLEN_W-1:0] xfer_len,
   output logic              tc_flag
);
   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 4");
      assert (CMD_DEPTH >= 2 && (CMD_DEPTH & (CMD_DEPTH - 1)) == 0)
         else $error("CMD_DEPTH must be a power of two");
      assert (CNT_W >= 8 && CNT_W <= 24)
         else $error("CNT_W out of range");
   end

   fifo_op_e op;

   always_comb begin
      if (status_load)    op = FOP_STATUS;
      else if (xfer_done) op = FOP_FLUSH;
      else                op = FOP_RW;
   end

   byte_fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .push      (wr_en && !cmd_pend),
      .push_data (wr_data),
      .pop       (rd_en),
      .zero_out  (phase == 2'b00),
      .stat_data (status_byte),
      .rd_data   (rd_data),
      .level     (fill_level),
      .popped    (pop_irq)
   );

   cmd_buffer #(.DW(DW), .CMD_DEPTH(CMD_DEPTH)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en && cmd_pend),
      .push_data (wr_data),
      .clear     (cmd_take),
      .rd_addr   (cmd_rd_addr),
      .rd_data   (cmd_rd_data),
      .len       (cmd_len)
   );

   xfer_counter #(.CNT_W(CNT_W), .CMD_CAP(CMD_DEPTH), .LVL_W(LVL_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .value    (cnt_value),
      .done     (xfer_done),
      .cmd_mode (cmd_pend),
      .level    (fill_level),
      .len      (xfer_len),
      .tc       (tc_flag)
   );
endmodule

// File: rtl/pio_xfer_fifo_chk.sv
module pio_xfer_fifo_chk #(
   parameter int DEPTH     = 16,
   parameter int CMD_DEPTH = 32,
   localparam int LVL_W  = $clog2(DEPTH) + 1,
   localparam int CLEN_W = $clog2(CMD_DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              cmd_pend,
   input logic              xfer_done,
   input logic              status_load,
   input logic [7:0]        rd_data,
   input logic              pop_irq,
   input logic [LVL_W-1:0]  fill_level,
   input logic [CLEN_W-1:0] cmd_len,
   input logic [16:0]       xfer_len,
   input logic              tc_flag
);
   logic quiet;
   assign quiet = !status_load && !xfer_done;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= LVL_W'(DEPTH - 1)); // R3
   AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && wr_en && !cmd_pend && !rd_en && fill_level == LVL_W'(DEPTH - 1))
      |=> fill_level == LVL_W'(DEPTH - 1)); // R3
   AST_POP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && rd_en && fill_level != '0) |=> pop_irq); // R2
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && rd_en && !wr_en && fill_level == '0)
      |=> ($stable(rd_data) && !pop_irq && fill_level == '0)); // R6
   AST_CMD_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && wr_en && cmd_pend && !rd_en) |=> $stable(fill_level)); // R4
   AST_CMD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_len <= CLEN_W'(CMD_DEPTH)); // R4
   AST_LEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_pend |-> xfer_len <= 17'(fill_level)); // R7
   AST_LEN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pend |-> xfer_len <= 17'(CMD_DEPTH)); // R8
   AST_DONE_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !status_load) |=> (tc_flag && fill_level == '0)); // R9
   AST_STATUS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      status_load |=> fill_level == LVL_W'(2)); // R10
endmodule

bind pio_xfer_fifo pio_xfer_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (.*);

// File: tb/tb_pio_xfer_fifo.sv
module tb_pio_xfer_fifo;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, cmd_pend = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  phase = 2'b01;
   logic        cnt_load = 1'b0, xfer_done = 1'b0, status_load = 1'b0, cmd_take = 1'b0;
   logic [15:0] cnt_value = '0;
   logic [7:0]  status_byte = '0;
   logic [4:0]  cmd_rd_addr = '0;
   logic [7:0]  rd_data, cmd_rd_data;
   logic        pop_irq, tc_flag;
   logic [4:0]  fill_level;
   logic [5:0]  cmd_len;
   logic [16:0] xfer_len;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   pio_xfer_fifo dut (.*);

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: every pop pulse must match the front of the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && pop_irq) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 unexpected pop: actual %0h expected none", rd_data);
         end else begin
            check("R2", "popped byte", int'(rd_data), int'(exp_q.pop_front()));
         end
      end
   end

   task automatic push_byte(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pop_byte(input logic [7:0] exp);
      exp_q.push_back(exp);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic load_cnt(input logic [15:0] v);
      @(negedge clk); cnt_load = 1'b1; cnt_value = v;
      @(negedge clk); cnt_load = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "fill", fill_level, 0);
      check("R1", "tc", tc_flag, 0);
      check("R1", "rd_data", rd_data, 0);
      check("R1", "cmd_len", cmd_len, 0);
      check("R1", "pop_irq", pop_irq, 0);
      check("R1", "xfer_len", xfer_len, 0);

      // R2 / R7: ordered data path and length cap by fill
      push_byte(8'hA1); push_byte(8'hA2); push_byte(8'hA3);
      check("R2", "fill after 3 writes", fill_level, 3);
      check("R7", "zero count capped by fill", xfer_len, 3);
      load_cnt(16'd2);
      check("R7", "count 2 vs fill 3", xfer_len, 2);
      load_cnt(16'h0000);
      pop_byte(8'hA1); pop_byte(8'hA2); pop_byte(8'hA3);
      check("R2", "fill after drain", fill_level, 0);

      // R6: empty read
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      check("R6", "rd_data held", rd_data, 8'hA3);
      check("R6", "no pop pulse", pop_irq, 0);
      check("R6", "fill stays 0", fill_level, 0);

      // R3: overrun at 15 held
      for (int i = 0; i < 16; i++) push_byte(8'h10 + 8'(i));
      check("R3", "fill saturates", fill_level, 15);
      for (int i = 0; i < 15; i++) pop_byte(8'h10 + 8'(i));
      check("R3", "fill after drain", fill_level, 0);

      // R5: data-out phase reads return zero
      push_byte(8'h44); push_byte(8'h55);
      phase = 2'b00;
      pop_byte(8'h00); pop_byte(8'h00);
      check("R5", "fill after data-out reads", fill_level, 0);
      phase = 2'b01;

      // R4 / R8: command phase
      cmd_pend = 1'b1;
      push_byte(8'h21); push_byte(8'h22); push_byte(8'h23);
      check("R4", "cmd_len", cmd_len, 3);
      check("R4", "fifo untouched", fill_level, 0);
      cmd_rd_addr = 5'd1; #1;
      check("R4", "cmd entry 1", cmd_rd_data, 8'h22);
      check("R8", "zero count in cmd phase", xfer_len, 32);
      load_cnt(16'd5);
      check("R8", "count 5 in cmd phase", xfer_len, 5);
      for (int i = 0; i < 40; i++) push_byte(8'(i));
      check("R4", "cmd_len saturates", cmd_len, 32);
      cmd_rd_addr = 5'd31; #1;
      check("R4", "last cmd entry", cmd_rd_data, 28);
      @(negedge clk); cmd_take = 1'b1;
      @(negedge clk); cmd_take = 1'b0;
      check("R4", "cmd_len cleared", cmd_len, 0);
      cmd_pend = 1'b0;

      // R9: transfer done
      push_byte(8'h61); push_byte(8'h62);
      load_cnt(16'd7);
      check("R7", "count 7 vs fill 2", xfer_len, 2);
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
      check("R9", "tc set", tc_flag, 1);
      check("R9", "fifo emptied", fill_level, 0);
      cmd_pend = 1'b1; #1;
      check("R9", "count cleared reads as 65536", xfer_len, 32);
      cmd_pend = 1'b0;
      load_cnt(16'd4);
      check("R9", "tc cleared by load", tc_flag, 0);

      // R10: status reply
      phase = 2'b11;
      push_byte(8'h99);
      @(negedge clk); status_load = 1'b1; status_byte = 8'h5A;
      @(negedge clk); status_load = 1'b0;
      check("R10", "fill after status", fill_level, 2);
      pop_byte(8'h5A); pop_byte(8'h00);

      // R11: status, done and write in one cycle
      @(negedge clk); status_load = 1'b1; status_byte = 8'hC3;
                      xfer_done = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
      @(negedge clk); status_load = 1'b0; xfer_done = 1'b0; wr_en = 1'b0;
      check("R11", "fill is reply only", fill_level, 2);
      check("R11", "tc still set", tc_flag, 1);
      pop_byte(8'hC3); pop_byte(8'h00);
      check("R11", "fill after reply drain", fill_level, 0);

      @(negedge clk);
      check("R2", "scoreboard empty", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule